// File: doc/BRIEF.md
# MDIO Management Bus Master with Register Front End

This block is a management-interface master that drives the two-wire MDC/MDIO bus towards Ethernet PHYs. It can run both Clause 22 and Clause 45 frames. Software sees five registers on a simple single-cycle write and combinational read bus:

- A command word launches a frame. It carries the start bit, a frame-type field, an opcode, a port address and a device or register address.
- Two data registers hold the 16-bit value for a Clause 45 address frame and the 16-bit value for a write frame.
- The last value read from the bus is held in a read-only register.
- A status flag reports whether the last read got an answer.

One command produces exactly one frame. A Clause 45 access is therefore two commands issued back to back: an address frame, then a read, write or read-increment frame. Software polls the start bit, which stays at one while the frame runs.

The frame engine is a state machine with five states:

- `S_IDLE` goes to `S_PREAMBLE` on launch.
- `S_PREAMBLE` sends 32 ones, then goes to `S_HEADER`.
- `S_HEADER` sends the start code, opcode, port and device fields (14 bits), then goes to `S_TURN`.
- `S_TURN` covers the two turnaround bits, then goes to `S_DATA`.
- `S_DATA` covers the 16 data bits, then goes back to `S_IDLE`.

Every transition happens when MDC falls. MDC is the system clock divided by an even parameter. Output bits change on the falling edge of MDC and input bits are sampled on its rising edge. During the turnaround and data bits of a read frame the pin is released by dropping the output enable.

Top module: `mdio_mgmt_master`

## Requirements
- R1: Register offsets are: 0x00 command, 0x04 address (low 16 bits kept), 0x08 write data (low 16 bits kept), 0x0C read data (read-only, low 16 bits) and 0x10 status (bit 0, read-only). Bus writes to the two read-only offsets change nothing. Unused read bits return 0.
- R2: The command word is laid out as follows: bits 4:0 device or register address, bits 9:5 port, bits 11:10 opcode, bits 13:12 frame type. Writing it with bit 14 set launches a frame. Bit 14 reads 1 for exactly 64×DIV system cycles after the launching write and then reads 0.
- R3: A write to the command word while bit 14 reads 1 is ignored. The stored fields are unchanged and no extra frame follows.
- R4: MDC is low while idle. It toggles every DIV/2 system cycles during a frame and gives exactly 64 rising edges per frame.
- R5: The frame is sent MSB first, one bit per MDC period:
  - 32 ones;
  - the start code, which is 00 when the frame type is 0 (Clause 45) and 01 otherwise (Clause 22);
  - the opcode;
  - the 5-bit port;
  - the 5-bit device field;
  - 2 turnaround bits;
  - 16 data bits.
- R6: A frame whose opcode bit 1 is 0 is a write frame. It drives turnaround 1,0, then 16 data bits. The data bits come from the address register for frame type 0 with opcode 0, and from the write-data register otherwise.
- R7: A frame whose opcode bit 1 is 1 is a read frame. The output enable is high for the first 46 bits and low for the last 18. It is high for all 64 bits of a write frame, and low while idle.
- R8: A read frame loads the 16 values sampled on the MDIO input at the rising MDC edges of bits 48 to 63, MSB first, into the read-data register.
- R9: At the end of a read frame, status bit 0 becomes 1 if MDIO was high at the rising MDC edge of bit 47 (the second turnaround bit), and 0 otherwise. Write frames leave it unchanged.
- R10: After reset, the following all hold:
  - every register reads 0;
  - MDC is 0;
  - the output enable is 0;
  - the MDIO output is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | AW (5) | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for `bus_addr`, combinational |
| mdc | output | 1 | Management clock to the PHYs |
| mdio_o | output | 1 | MDIO value driven by the master |
| mdio_oe | output | 1 | MDIO output enable; the pad drives `mdio_o` when high |
| mdio_i | input | 1 | MDIO value seen at the pad |

## Verification
If the bit counter or the state is wrong, it shows at once as a misplaced field in the bit sequence captured at the MDC rising edges. It also shows as a rising-edge count other than 64, or a busy window other than 64×DIV cycles, visible when that frame completes.

An output enable released at the wrong bit corrupts the captured header, or the turnaround answer, of that same frame. A wrong capture point for input bits, or a wrong turnaround sample, is seen at the first read-data or status readback after the frame.

The bench sweeps:
- every frame type and opcode;
- two port/device patterns;
- answering and silent PHYs;
- a command written mid-frame.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    // frame geometry, in MDC periods
    localparam int PRE_BITS   = 32;
    localparam int HDR_BITS   = 14;
    localparam int TA_BITS    = 2;
    localparam int DAT_BITS   = 16;
    localparam int FRAME_BITS = PRE_BITS + HDR_BITS + TA_BITS + DAT_BITS;
    localparam int SHIFT_BITS = FRAME_BITS - PRE_BITS;
    localparam int IDX_W      = $clog2(FRAME_BITS);

    // last bit index of each phase
    localparam int PRE_LAST  = PRE_BITS - 1;
    localparam int HDR_LAST  = PRE_LAST + HDR_BITS;
    localparam int TA_LAST   = HDR_LAST + TA_BITS;
    localparam int DAT_LAST  = FRAME_BITS - 1;

    // register offsets and command layout
    localparam int REG_W     = 32;
    localparam int OFS_CMD   = 'h00;
    localparam int OFS_ADDR  = 'h04;
    localparam int OFS_WDAT  = 'h08;
    localparam int OFS_RDAT  = 'h0C;
    localparam int OFS_STAT  = 'h10;
    localparam int GO_BIT    = 14;

    typedef struct packed {
        logic [1:0] ftype;   // 0 = clause 45, others = clause 22
        logic [1:0] op;
        logic [4:0] port;
        logic [4:0] dev;
    } cmd_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PREAMBLE,
        S_HEADER,
        S_TURN,
        S_DATA
    } frame_state_t;

endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic mdc_o,
    output logic rise_o,
    output logic fall_o
);
    localparam int HALF = DIV / 2;
    localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

    logic mdc_q;
    logic tick;

    generate
        if (HALF == 1) begin : g_direct
            assign tick = run_i;
        end else begin : g_count
            logic [CW-1:0] cnt;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    cnt <= '0;
                else if (!run_i || cnt == CW'(HALF - 1))
                    cnt <= '0;
                else
                    cnt <= cnt + 1'b1;
            end
            assign tick = run_i && (cnt == CW'(HALF - 1));
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            mdc_q <= 1'b0;
        else if (!run_i)
            mdc_q <= 1'b0;
        else if (tick)
            mdc_q <= ~mdc_q;
    end

    assign mdc_o  = mdc_q;
    assign rise_o = tick && !mdc_q;
    assign fall_o = tick && mdc_q;

    // R4: MDC parks low once the engine stops
    p_mdc_parks_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> !mdc_o);
    // R4: a rising strobe leaves MDC high
    p_rise_lifts_mdc_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> mdc_o);

endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
    import mdio_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic [1:0]  sc_i,
    input  logic [1:0]  op_i,
    input  logic [4:0]  port_i,
    input  logic [4:0]  dev_i,
    input  logic [15:0] data_i,
    input  logic        rise_i,
    input  logic        fall_i,
    input  logic        mdio_i,
    output logic        busy_o,
    output logic        done_o,
    output logic        rd_mode_o,
    output logic [15:0] rd_data_o,
    output logic        rd_fail_o,
    output logic        mdio_o,
    output logic        mdio_oe_o
);
    frame_state_t          state;
    logic [IDX_W-1:0]      idx;
    logic [SHIFT_BITS-1:0] tx_sr;
    logic [DAT_BITS-1:0]   rx_sr;
    logic                  rd_mode;
    logic                  ta_high;
    logic                  launch;

    assign launch = start_i && (state == S_IDLE);
    assign done_o = fall_i && (state == S_DATA) && (idx == IDX_W'(DAT_LAST));

    // state register, bit counter and shift registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            idx     <= '0;
            tx_sr   <= '0;
            rx_sr   <= '0;
            rd_mode <= 1'b0;
            ta_high <= 1'b0;
        end else if (launch) begin
            state   <= S_PREAMBLE;
            idx     <= '0;
            tx_sr   <= {sc_i, op_i, port_i, dev_i, 2'b10, data_i};
            rd_mode <= op_i[1];
            ta_high <= 1'b0;
        end else if (state != S_IDLE) begin
            if (rise_i) begin
                if (state == S_TURN && idx == IDX_W'(TA_LAST))
                    ta_high <= mdio_i;
                if (state == S_DATA)
                    rx_sr <= {rx_sr[DAT_BITS-2:0], mdio_i};
            end
            if (fall_i) begin
                idx <= idx + 1'b1;
                if (state != S_PREAMBLE)
                    tx_sr <= {tx_sr[SHIFT_BITS-2:0], 1'b0};
                unique case (state)
                    S_PREAMBLE: if (idx == IDX_W'(PRE_LAST)) state <= S_HEADER;
                    S_HEADER:   if (idx == IDX_W'(HDR_LAST)) state <= S_TURN;
                    S_TURN:     if (idx == IDX_W'(TA_LAST))  state <= S_DATA;
                    S_DATA:     if (idx == IDX_W'(DAT_LAST)) state <= S_IDLE;
                    default:    state <= S_IDLE;
                endcase
            end
        end
    end

    // pin outputs from state
    always_comb begin
        mdio_o    = 1'b1;
        mdio_oe_o = 1'b0;
        unique case (state)
            S_IDLE: begin
                mdio_o    = 1'b1;
                mdio_oe_o = 1'b0;
            end
            S_PREAMBLE: begin
                mdio_o    = 1'b1;
                mdio_oe_o = 1'b1;
            end
            S_HEADER: begin
                mdio_o    = tx_sr[SHIFT_BITS-1];
                mdio_oe_o = 1'b1;
            end
            S_TURN, S_DATA: begin
                mdio_o    = rd_mode ? 1'b1 : tx_sr[SHIFT_BITS-1];
                mdio_oe_o = !rd_mode;
            end
            default: begin
                mdio_o    = 1'b1;
                mdio_oe_o = 1'b0;
            end
        endcase
    end

    assign busy_o    = (state != S_IDLE);
    assign rd_mode_o = rd_mode;
    assign rd_data_o = rx_sr;
    assign rd_fail_o = ta_high;

    // checker: MDC rising edges since launch
    logic [IDX_W:0] rise_cnt;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rise_cnt <= '0;
        else if (launch)
            rise_cnt <= '0;
        else if (rise_i)
            rise_cnt <= rise_cnt + 1'b1;
    end

    // R4: a frame ends after exactly 64 rising MDC edges
    p_edge_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (rise_cnt == (IDX_W+1)'(FRAME_BITS)));
    // R5: the driven bit moves only with a falling MDC or a launch
    p_bit_on_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mdio_o) |-> ($past(fall_i) || $past(start_i)));
    // R7: pin released while idle
    p_idle_released_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE) |-> !mdio_oe_o);
    // R7: pin released during the data phase of a read
    p_read_released_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DATA && rd_mode) |-> !mdio_oe_o);

endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
    import mdio_pkg::*;
#(
    parameter int AW  = 5,
    parameter int DIV = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [31:0]   bus_wdata,
    output logic [31:0]   bus_rdata,
    output logic          mdc,
    output logic          mdio_o,
    output logic          mdio_oe,
    input  logic          mdio_i
);
    localparam int CMD_W = $bits(cmd_t);

    cmd_t        cmd_q;
    logic [15:0] addr_q;
    logic [15:0] wdat_q;
    logic [15:0] rdat_q;
    logic        fail_q;

    logic        busy;
    logic        eng_done;
    logic        eng_rd;
    logic [15:0] eng_rdata;
    logic        eng_fail;
    logic        rise_stb;
    logic        fall_stb;

    cmd_t        new_cmd;
    logic        cmd_wr;
    logic        launch;
    logic [1:0]  new_sc;
    logic [15:0] new_data;
    logic        unused_wdata_hi;

    assign new_cmd  = cmd_t'(bus_wdata[CMD_W-1:0]);
    assign cmd_wr   = bus_wr && (bus_addr == AW'(OFS_CMD)) && !busy;
    assign launch   = cmd_wr && bus_wdata[GO_BIT];
    assign new_sc   = (new_cmd.ftype == 2'b00) ? 2'b00 : 2'b01;
    assign new_data = (new_cmd.ftype == 2'b00 && new_cmd.op == 2'b00) ? addr_q : wdat_q;
    assign unused_wdata_hi = ^bus_wdata[31:16];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q  <= '0;
            addr_q <= '0;
            wdat_q <= '0;
            rdat_q <= '0;
            fail_q <= 1'b0;
        end else begin
            if (cmd_wr)
                cmd_q <= new_cmd;
            if (bus_wr && bus_addr == AW'(OFS_ADDR))
                addr_q <= bus_wdata[15:0];
            if (bus_wr && bus_addr == AW'(OFS_WDAT))
                wdat_q <= bus_wdata[15:0];
            if (eng_done && eng_rd) begin
                rdat_q <= eng_rdata;
                fail_q <= eng_fail;
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            AW'(OFS_CMD):  bus_rdata = {{(REG_W-GO_BIT-1){1'b0}}, busy, cmd_q};
            AW'(OFS_ADDR): bus_rdata = {16'h0, addr_q};
            AW'(OFS_WDAT): bus_rdata = {16'h0, wdat_q};
            AW'(OFS_RDAT): bus_rdata = {16'h0, rdat_q};
            AW'(OFS_STAT): bus_rdata = {31'h0, fail_q};
            default:       bus_rdata = '0;
        endcase
    end

    mdio_clkdiv #(.DIV(DIV)) u_clkdiv (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (busy),
        .mdc_o  (mdc),
        .rise_o (rise_stb),
        .fall_o (fall_stb)
    );

    mdio_frame_engine u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (launch),
        .sc_i      (new_sc),
        .op_i      (new_cmd.op),
        .port_i    (new_cmd.port),
        .dev_i     (new_cmd.dev),
        .data_i    (new_data),
        .rise_i    (rise_stb),
        .fall_i    (fall_stb),
        .mdio_i    (mdio_i),
        .busy_o    (busy),
        .done_o    (eng_done),
        .rd_mode_o (eng_rd),
        .rd_data_o (eng_rdata),
        .rd_fail_o (eng_fail),
        .mdio_o    (mdio_o),
        .mdio_oe_o (mdio_oe)
    );

    // R3: command fields frozen against writes during a frame
    p_cmd_locked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && bus_wr && bus_addr == AW'(OFS_CMD)) |=> $stable(cmd_q));
    // R9: the status flag moves only at the end of a read frame
    p_fail_on_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(fail_q) |-> $past(eng_done && eng_rd));
    // R8: read data moves only at the end of a read frame
    p_rdata_on_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rdat_q) |-> $past(eng_done && eng_rd));

endmodule

// File: tb/test_mdio_mgmt_master.sv
module test_mdio_mgmt_master;
    localparam int DIV = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        mdc, mdio_o, mdio_oe, mdio_i;

    int n_chk = 0;
    int n_bad = 0;

    // PHY model state
    logic        phy_drive = 1'b1;
    logic        phy_rd = 1'b0;
    logic        phy_resp = 1'b1;
    logic [15:0] phy_data = '0;
    logic        mdc_prev = 1'b0;
    int          nrise = 0;
    int          busy_cycles = 0;
    logic [63:0] cap_o, cap_oe;

    logic [15:0] cur_addr = '0, cur_wdat = '0, exp_rdat = '0;
    logic        exp_fail = 1'b0;

    always #4 clk = ~clk;

    assign mdio_i = mdio_oe ? mdio_o : phy_drive;

    mdio_mgmt_master #(.AW(5), .DIV(DIV)) i_mdio_mgmt_master (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    function automatic logic phy_bit(input int j);
        if (!phy_rd) return 1'b1;
        if (j == 47) return !phy_resp;
        if (j >= 48 && j <= 63) return phy_resp ? phy_data[63-j] : 1'b1;
        return 1'b1;
    endfunction

    always @(negedge clk) begin
        if (mdc && !mdc_prev) begin
            if (nrise < 64) begin
                cap_o[nrise]  = mdio_o;
                cap_oe[nrise] = mdio_oe;
            end
            nrise = nrise + 1;
            phy_drive = phy_bit(nrise);
        end
        mdc_prev = mdc;
        if (bus_addr == 5'h00 && bus_rdata[14]) busy_cycles = busy_cycles + 1;
    end

    task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 5'h00; bus_wdata = '0;
    endtask

    task automatic reg_read(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
        bus_addr = 5'h00;
    endtask

    task automatic run_frame(input logic [1:0] ft, input logic [1:0] op,
                             input logic [4:0] port, input logic [4:0] dev,
                             input logic resp, input logic lock);
        logic [63:0] frm, exp_o, exp_oe;
        logic [1:0]  sc;
        logic [15:0] dat;
        logic [31:0] cmdw, rv;
        logic        rd;
        rd   = op[1];
        sc   = (ft == 2'd0) ? 2'b00 : 2'b01;
        dat  = (ft == 2'd0 && op == 2'd0) ? cur_addr : cur_wdat;
        frm  = {32'hFFFF_FFFF, sc, op, port, dev, 2'b10, dat};
        for (int k = 0; k < 64; k++) begin
            exp_o[k]  = frm[63-k];
            exp_oe[k] = rd ? (k < 46) : 1'b1;
        end
        phy_rd = rd; phy_resp = resp; phy_data = cur_addr ^ 16'h5A5A;
        nrise = 0; busy_cycles = 0;
        cmdw = {17'h0, 1'b1, ft, op, port, dev};
        reg_write(5'h00, cmdw);
        if (lock) begin
            repeat (20) @(negedge clk);
            reg_write(5'h00, {17'h0, 1'b1, ~ft, ~op, ~port, ~dev});
            #1 chk(bus_rdata == cmdw, "R3 locked command fields", {32'h0, bus_rdata}, {32'h0, cmdw});
        end
        while (bus_rdata[14]) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(bus_rdata[14] == 1'b0, "R3 no extra frame", {63'h0, bus_rdata[14]}, 64'h0);
        chk(nrise == 64, "R4 rising edges", 64'(nrise), 64'd64);
        chk(busy_cycles == 64*DIV, "R2 busy window", 64'(busy_cycles), 64'(64*DIV));
        chk(mdc == 1'b0, "R4 mdc idle low", {63'h0, mdc}, 64'h0);
        chk((cap_o & exp_oe) == (exp_o & exp_oe), rd ? "R5 read header bits" : "R6 write frame bits",
            cap_o & exp_oe, exp_o & exp_oe);
        chk(cap_oe == exp_oe, "R7 output enable pattern", cap_oe, exp_oe);
        if (rd) begin
            exp_rdat = resp ? phy_data : 16'hFFFF;
            exp_fail = !resp;
        end
        reg_read(5'h0C, rv);
        chk(rv == {16'h0, exp_rdat}, "R8 read data", {32'h0, rv}, {48'h0, exp_rdat});
        reg_read(5'h10, rv);
        chk(rv == {31'h0, exp_fail}, "R9 status flag", {32'h0, rv}, {63'h0, exp_fail});
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        logic [31:0] rv;
        int          n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10 reset state
        #1 chk(mdc == 1'b0 && mdio_oe == 1'b0 && mdio_o == 1'b1, "R10 pins after reset",
               {61'h0, mdc, mdio_oe, mdio_o}, 64'h1);
        for (int a = 0; a <= 16; a += 4) begin
            reg_read(5'(a), rv);
            chk(rv == 32'h0, "R10 register after reset", {32'h0, rv}, 64'h0);
        end
        // R1 register widths and read-only offsets
        reg_write(5'h04, 32'hDEAD_BEEF);
        reg_read(5'h04, rv);
        chk(rv == 32'h0000_BEEF, "R1 address register", {32'h0, rv}, 64'hBEEF);
        reg_write(5'h08, 32'h1234_CAFE);
        reg_read(5'h08, rv);
        chk(rv == 32'h0000_CAFE, "R1 write-data register", {32'h0, rv}, 64'hCAFE);
        reg_write(5'h0C, 32'hFFFF_FFFF);
        reg_write(5'h10, 32'hFFFF_FFFF);
        reg_read(5'h0C, rv);
        chk(rv == 32'h0, "R1 read-data is read-only", {32'h0, rv}, 64'h0);
        reg_read(5'h10, rv);
        chk(rv == 32'h0, "R1 status is read-only", {32'h0, rv}, 64'h0);
        reg_write(5'h00, 32'h0000_1ABC);
        reg_read(5'h00, rv);
        chk(rv == 32'h0000_1ABC, "R2 command fields without start", {32'h0, rv}, 64'h1ABC);

        // sweep frame types, opcodes, two port/device patterns
        n = 0;
        for (int ft = 0; ft < 4; ft++) begin
            for (int op = 0; op < 4; op++) begin
                for (int pd = 0; pd < 2; pd++) begin
                    cur_addr = 16'(16'h0137 * (n + 1) ^ 16'hA5C3);
                    cur_wdat = 16'(~cur_addr + 16'(n * 3));
                    reg_write(5'h04, {16'hFFFF, cur_addr});
                    reg_write(5'h08, {16'hFFFF, cur_wdat});
                    run_frame(2'(ft), 2'(op),
                              pd == 0 ? 5'(ft * 7 + op) : 5'(5'h1F ^ 5'(n)),
                              pd == 0 ? 5'(31 - op * 3) : 5'(n * 5 + 1),
                              ((ft + op + pd) % 5) != 4,
                              (n == 5) || (n == 22));
                    n++;
                end
            end
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule